// File: doc/BRIEF.md
# Sleep Entry and Warm-Start Sequencer

This block governs the RAM-retention sleep state of a small microcontroller core. The instruction decoder hands it strobes for three instructions: an arming instruction, a power-off instruction and a test instruction that skips when the warm-start flag is set. Sleep begins only when power-off is the next executed instruction after arming. On entry the block stops the core clock. It pulses one strobe per group of core state that must be re-initialised, and it sets a flag that survives the sleep.

An external wakeup is captured by a flop with an asynchronous set, so it is caught even with no clock edge pending. The sequencer then holds the core in a short restart phase and asks for the program counter to be forced to address 0 of page 0. A pin reset, a watchdog reset or a low-voltage detection goes through the same restart phase, but it clears the flag. Software can therefore run the test instruction and tell a warm start from a cold one.

Top module: `pwrdn_ctrl`

## Requirements
- R1: A valid power-off instruction with no arming instruction as the previous valid instruction is a no-operation: clk_stop_o stays 0 and warm_flag_o keeps its value.
- R2: A valid arming instruction followed by a valid power-off instruction raises clk_stop_o at the next clock edge. Cycles with instr_valid_i low between them do not cancel the arm. clk_stop_o then stays 1 until a wakeup or a cold start.
- R3: Any other valid instruction between arming and power-off cancels the arm. A cold start in the cycle of the power-off also cancels it, and that cold start wins.
- R4: In the first sleep cycle, init_core_o, init_sp_o and init_wdt_o are each 1 for exactly one cycle. sp_value_o carries all ones (binary 111 at the default width).
- R5: warm_flag_o becomes 1 in the same cycle that clk_stop_o rises.
- R6: While asleep, a rising wake_i is captured asynchronously. clk_stop_o falls at the second rising clock edge after wake_i rises. pc_restart_o is then 1 for RESTART_CYC (default 2) cycles and returns to 0, and warm_flag_o stays 1.
- R7: wdt_rst_i or lvd_i high at a clock edge gives pc_restart_o=1, clk_stop_o=0 and warm_flag_o=0 after that edge, from any state.
- R8: rst_ni low immediately forces clk_stop_o=0, warm_flag_o=0, pc_restart_o=1 and all init strobes 0. After release, pc_restart_o stays 1 for three more rising edges and is 0 after the fourth.
- R9: A cold-start source that coincides with a synchronised wakeup wins, and warm_flag_o ends at 0.
- R10: skip_o is 1 exactly when instr_valid_i and tst_op_i are high while the core runs with warm_flag_o at 1.
- R11: While the core runs, wake_i has no effect: pc_restart_o and clk_stop_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset pin |
| wdt_rst_i | input | 1 | Watchdog reset request (synchronous) |
| lvd_i | input | 1 | Low-voltage detect (synchronous) |
| wake_i | input | 1 | External wakeup, asynchronous |
| instr_valid_i | input | 1 | An instruction executes this cycle |
| arm_op_i | input | 1 | Decoded arming instruction |
| off_op_i | input | 1 | Decoded power-off instruction |
| tst_op_i | input | 1 | Decoded skip-on-warm-flag test |
| clk_stop_o | output | 1 | Stop the core clock |
| init_core_o | output | 1 | Re-initialise PC, accumulator, secondary register, carry, interrupt enable |
| init_sp_o | output | 1 | Load stack pointer with sp_value_o |
| init_wdt_o | output | 1 | Re-initialise watchdog flags, enable and counter |
| sp_value_o | output | SP_W | Stack pointer load value (all ones) |
| pc_restart_o | output | 1 | Hold the core and force the PC to page 0, address 0 |
| warm_flag_o | output | 1 | Warm-start flag |
| skip_o | output | 1 | Skip condition for the test instruction |

## Verification
A stale arm latch shows up on the first power-off after an intervening instruction. In that case clk_stop_o rises at the next edge when it should stay low. A wrong sequencer state reaches the ports within one cycle, because clk_stop_o and pc_restart_o are decoded straight from it. A restart counter that is off by one moves the fall of pc_restart_o by one cycle after a wakeup or a cold start. A lost priority between cold start and wakeup leaves warm_flag_o at 1 in the cycle right after the coincident edge, and skip_o then fires on the next test instruction.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef enum logic [1:0] {
    PD_RUN   = 2'd0,
    PD_SLEEP = 2'd1,
    PD_HOLD  = 2'd2
  } pd_state_e;
endpackage

// File: rtl/pd_rst_sync.sv
module pd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      assign sh_d = 1'b1;
    end else begin : g_many
      assign sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_sync_no = sh_q[STAGES-1];
endmodule

// File: rtl/pd_wake_sync.sv
module pd_wake_sync #(
  parameter int DEPTH = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wake_i,
  output logic wake_o
);
  logic cap_q;
  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  // capture flop: set asynchronously by the wakeup level
  always_ff @(posedge clk_i or negedge rst_ni or posedge wake_i) begin
    if (!rst_ni)     cap_q <= 1'b0;
    else if (wake_i) cap_q <= 1'b1;
    else             cap_q <= 1'b0;
  end

  generate
    if (DEPTH == 1) begin : g_one
      assign sh_d = cap_q;
    end else begin : g_many
      assign sh_d = {sh_q[DEPTH-2:0], cap_q};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign wake_o = sh_q[DEPTH-1];
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int RESTART_CYC = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cold_i,
  input  logic      wake_i,
  input  logic      instr_valid_i,
  input  logic      arm_op_i,
  input  logic      off_op_i,
  output pd_state_e state_o,
  output logic      flag_o,
  output logic      init_o
);
  localparam int CNT_W = $clog2(RESTART_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_CYC - 1);

  pd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             flag_q, flag_d;
  logic             init_q, init_d;
  logic             enter;

  assign enter = (state_q == PD_RUN) && instr_valid_i && off_op_i && arm_q;

  always_comb begin
    arm_d = arm_q;
    if (cold_i || (state_q != PD_RUN)) arm_d = 1'b0;
    else if (instr_valid_i)            arm_d = arm_op_i && !off_op_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    flag_d  = flag_q;
    init_d  = 1'b0;
    if (cold_i) begin
      state_d = PD_HOLD;
      cnt_d   = '0;
      flag_d  = 1'b0;
    end else begin
      unique case (state_q)
        PD_RUN: begin
          if (enter) begin
            state_d = PD_SLEEP;
            flag_d  = 1'b1;
            init_d  = 1'b1;
          end
        end
        PD_SLEEP: begin
          if (wake_i) begin
            state_d = PD_HOLD;
            cnt_d   = '0;
          end
        end
        PD_HOLD: begin
          if (cnt_q == CNT_LAST) state_d = PD_RUN;
          else                   cnt_d   = cnt_q + CNT_W'(1);
        end
        default: state_d = PD_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PD_HOLD;
      cnt_q   <= '0;
      arm_q   <= 1'b0;
      flag_q  <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      arm_q   <= arm_d;
      flag_q  <= flag_d;
      init_q  <= init_d;
    end
  end

  assign state_o = state_q;
  assign flag_o  = flag_q;
  assign init_o  = init_q;
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pd_pkg::*;
#(
  parameter int RST_STAGES  = 2,
  parameter int WAKE_DEPTH  = 1,
  parameter int RESTART_CYC = 2,
  parameter int SP_W        = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wdt_rst_i,
  input  logic            lvd_i,
  input  logic            wake_i,
  input  logic            instr_valid_i,
  input  logic            arm_op_i,
  input  logic            off_op_i,
  input  logic            tst_op_i,
  output logic            clk_stop_o,
  output logic            init_core_o,
  output logic            init_sp_o,
  output logic            init_wdt_o,
  output logic [SP_W-1:0] sp_value_o,
  output logic            pc_restart_o,
  output logic            warm_flag_o,
  output logic            skip_o
);
  logic      rst_sync_n;
  logic      wake_sync;
  logic      cold;
  logic      flag;
  logic      init_pulse;
  pd_state_e state;

  pd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  pd_wake_sync #(.DEPTH(WAKE_DEPTH)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .wake_i (wake_i),
    .wake_o (wake_sync)
  );

  assign cold = wdt_rst_i || lvd_i;

  pd_seq #(.RESTART_CYC(RESTART_CYC)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_sync_n),
    .cold_i        (cold),
    .wake_i        (wake_sync),
    .instr_valid_i (instr_valid_i),
    .arm_op_i      (arm_op_i),
    .off_op_i      (off_op_i),
    .state_o       (state),
    .flag_o        (flag),
    .init_o        (init_pulse)
  );

  assign clk_stop_o   = (state == PD_SLEEP);
  assign pc_restart_o = (state == PD_HOLD);
  assign init_core_o  = init_pulse;
  assign init_sp_o    = init_pulse;
  assign init_wdt_o   = init_pulse;
  assign sp_value_o   = '1;
  assign warm_flag_o  = flag;
  assign skip_o       = (state == PD_RUN) && instr_valid_i && tst_op_i && flag;
endmodule

// File: rtl/pd_chk.sv
module pd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wdt_rst_i,
  input logic lvd_i,
  input logic instr_valid_i,
  input logic off_op_i,
  input logic tst_op_i,
  input logic clk_stop_o,
  input logic init_core_o,
  input logic pc_restart_o,
  input logic warm_flag_o,
  input logic skip_o
);
  // R2
  stop_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_stop_o) |-> $past(instr_valid_i && off_op_i));
  // R4
  init_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_core_o |-> (clk_stop_o && $past(!clk_stop_o)));
  // R5
  flag_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_stop_o) |-> warm_flag_o);
  // R7
  cold_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_i || lvd_i) |=> (pc_restart_o && !warm_flag_o && !clk_stop_o));
  // R10
  skip_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (warm_flag_o && tst_op_i && instr_valid_i));
  // R6
  stop_hold_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(clk_stop_o && pc_restart_o));
  // R11
  run_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_stop_o && !pc_restart_o && !wdt_rst_i && !lvd_i && !(instr_valid_i && off_op_i))
      |=> (!pc_restart_o && !clk_stop_o));
endmodule

bind pwrdn_ctrl pd_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wdt_rst_i     (wdt_rst_i),
  .lvd_i         (lvd_i),
  .instr_valid_i (instr_valid_i),
  .off_op_i      (off_op_i),
  .tst_op_i      (tst_op_i),
  .clk_stop_o    (clk_stop_o),
  .init_core_o   (init_core_o),
  .pc_restart_o  (pc_restart_o),
  .warm_flag_o   (warm_flag_o),
  .skip_o        (skip_o)
);

// File: tb/sim_pwrdn_ctrl.sv
module sim_pwrdn_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic clk = 1'b0;
  logic rst_n, wdt, lvd, wake, vld, arm, off, tst;
  logic stop, ic, isp, iwd, pcr, flag, skip;
  logic [2:0] spv;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wdt_rst_i(wdt), .lvd_i(lvd), .wake_i(wake),
    .instr_valid_i(vld), .arm_op_i(arm), .off_op_i(off), .tst_op_i(tst),
    .clk_stop_o(stop), .init_core_o(ic), .init_sp_o(isp), .init_wdt_o(iwd),
    .sp_value_o(spv), .pc_restart_o(pcr), .warm_flag_o(flag), .skip_o(skip)
  );

  // inputs {valid, arm, off, wdt, lvd} ; expected {stop, init, restart, flag}
  localparam logic [8:0] VEC [NVEC] = '{
    9'b10100_0000,  // R1 power-off alone
    9'b11000_0000,  // arm
    9'b10000_0000,  // R3 other instruction cancels
    9'b10100_0000,  // R3 power-off now a no-op
    9'b11000_0000,  // arm
    9'b10110_0010,  // R3 cold start wins over power-off
    9'b00000_0010,  // restart phase
    9'b00000_0000,  // running
    9'b11000_0000,  // arm
    9'b00000_0000,  // R2 bubble keeps the arm
    9'b10100_1101,  // R2 R4 R5 sleep entered
    9'b00000_1001   // R4 strobe lasts one cycle
  };

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic drive(input logic v, a, o, t, w, l);
    vld = v; arm = a; off = o; tst = t; wdt = w; lvd = l;
  endtask

  task automatic step(input logic v, a, o, t, w, l);
    drive(v, a, o, t, w, l);
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic enter_sleep();
    step(1, 1, 0, 0, 0, 0);
    step(1, 0, 1, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wake = 1'b0;
    drive(0, 0, 0, 0, 0, 0);
    #(CLK_PERIOD * 3 + 1);
    // R8 reset state
    chk(stop, 1'b0, "R8 reset clk_stop");
    chk(flag, 1'b0, "R8 reset flag");
    chk(pcr, 1'b1, "R8 reset restart");
    chk(ic, 1'b0, "R8 reset init");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk(pcr, 1'b1, "R8 restart held after third edge");
    @(posedge clk); @(negedge clk);
    chk(pcr, 1'b0, "R8 released after fourth edge");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], 1'b0, VEC[i][5], VEC[i][4]);
      chk(stop, VEC[i][3], $sformatf("vector %0d clk_stop", i));
      chk(ic && isp && iwd, VEC[i][2], $sformatf("vector %0d init strobes", i));
      chk(pcr, VEC[i][1], $sformatf("vector %0d restart", i));
      chk(flag, VEC[i][0], $sformatf("vector %0d flag", i));
    end
    chk(spv == 3'b111, 1'b1, "R4 stack pointer value");

    // R6 warm wakeup
    wake = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    chk(stop, 1'b1, "R6 still asleep after first edge");
    step(0, 0, 0, 0, 0, 0);
    chk(stop, 1'b0, "R6 clock released on second edge");
    chk(pcr, 1'b1, "R6 restart begins");
    wake = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    chk(pcr, 1'b1, "R6 restart second cycle");
    step(0, 0, 0, 0, 0, 0);
    chk(pcr, 1'b0, "R6 restart ends");
    chk(flag, 1'b1, "R6 warm flag set");

    // R11 wake while running
    wake = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk(pcr, 1'b0, "R11 no restart");
    chk(stop, 1'b0, "R11 no stop");
    wake = 1'b0;

    // R10 skip
    drive(1, 0, 0, 1, 0, 0); #1;
    chk(skip, 1'b1, "R10 skip with flag set");
    drive(0, 0, 0, 1, 0, 0); #1;
    chk(skip, 1'b0, "R10 no skip without valid");
    drive(0, 0, 0, 0, 0, 0);

    // R7 watchdog cold start while running
    step(0, 0, 0, 0, 1, 0);
    chk(pcr, 1'b1, "R7 watchdog restart");
    chk(flag, 1'b0, "R7 watchdog clears flag");
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    drive(1, 0, 0, 1, 0, 0); #1;
    chk(skip, 1'b0, "R10 no skip after cold start");
    drive(0, 0, 0, 0, 0, 0);

    // R7 low voltage while asleep
    enter_sleep();
    chk(stop, 1'b1, "R2 asleep again");
    step(0, 0, 0, 0, 0, 1);
    chk(stop, 1'b0, "R7 lvd leaves sleep");
    chk(pcr, 1'b1, "R7 lvd restart");
    chk(flag, 1'b0, "R7 lvd clears flag");
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R9 cold start coincides with synchronised wakeup
    enter_sleep();
    wake = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    chk(stop, 1'b1, "R9 wake not yet seen");
    step(0, 0, 0, 0, 1, 0);
    chk(pcr, 1'b1, "R9 restart");
    chk(flag, 1'b0, "R9 cold wins flag");
    wake = 1'b0;
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    // R8 pin reset while asleep
    enter_sleep();
    chk(flag, 1'b1, "R5 flag on entry");
    rst_n = 1'b0; #1;
    chk(stop, 1'b0, "R8 pin reset stops sleep");
    chk(flag, 1'b0, "R8 pin reset clears flag");
    chk(pcr, 1'b1, "R8 pin reset restart");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); @(negedge clk);
    end
    chk(pcr, 1'b0, "R8 running after release");
    finish_run();
  end
endmodule